// File: doc/BRIEF.md
# Address Decoder with Remap

This block turns a 32-bit processor address into a set of select lines. The internal memories sit in the bottom 4 MB of the space, the internal peripherals in the top 4 MB, and everything in between goes to the external bus interface. It also produces a region-relative offset and little-endian byte-lane enables for the access. When an access is not aligned, or falls in a part of the internal region where no memory exists, the block raises an abort flag.

The low window at address zero changes its meaning once. Out of reset, address zero goes to the external bus with a boot-select flag, so the reset vector comes from nonvolatile boot memory. After a single remap strobe, the 8 KB primary SRAM appears at zero and the exception vectors become writable. The primary SRAM can also be reached at all times through a fixed alias at 0x0030_0000. The remap state is sticky: only reset clears it.

Top module: `addr_remap_decoder`

## Requirements
- R1: After reset, `remap_active` is 0.
- R2: Addresses from 0xFFC0_0000 to 0xFFFF_FFFF select the peripheral region (`sel_region` bit 3), and the offset is the address minus 0xFFC0_0000.
- R3: Addresses from 0x0040_0000 to 0xFFBF_FFFF select the external bus (`sel_region` bit 2) with `boot_sel` = 0, and the offset is the full address.
- R4: While `remap_active` is 0, addresses 0x0000_0000 to 0x0000_1FFF select the external bus with `boot_sel` = 1, and the offset is the address.
- R5: While `remap_active` is 1, addresses 0x0000_0000 to 0x0000_1FFF select the primary SRAM (`sel_region` bit 0), and the offset is the address.
- R6: Addresses 0x0030_0000 to 0x0030_1FFF select the primary SRAM in both remap states, and the offset is the address minus 0x0030_0000.
- R7: Addresses 0x0010_0000 to 0x0011_FFFF select the extended bank (`sel_region` bit 1), and the offset is the address minus 0x0010_0000.
- R8: A valid aligned access to any other address below 0x0040_0000 raises `abort`. For such an access `sel_region`, `boot_sel`, `lane_en` and the offset are all 0.
- R9: A `remap_wr` pulse sets `remap_active` at the next clock edge. Further pulses leave it at 1, and only reset returns it to 0.
- R10: `lane_en` is little-endian. A byte access (`bus_size`=0) enables lane addr[1:0]. A halfword access (`bus_size`=1) enables 4'b0011 or 4'b1100, chosen by addr[1]. A word access (`bus_size`=2) enables 4'b1111.
- R11: A misaligned access raises `abort` with no select, no lanes and a zero offset. Misaligned means a halfword at an odd address, a word at an address that is not a multiple of 4, or `bus_size`=3.
- R12: While `bus_valid` is 0, `sel_region`, `boot_sel`, `abort`, `lane_en` and the offset are all 0, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 32 | Processor byte address |
| bus_valid | input | 1 | Access strobe |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| remap_wr | input | 1 | Remap command strobe |
| sel_region | output | 4 | One-hot select: bit0 primary SRAM, bit1 extended bank, bit2 external bus, bit3 peripherals |
| boot_sel | output | 1 | External access is the boot-memory fetch window |
| region_offset | output | 32 | Address relative to the selected region |
| lane_en | output | 4 | Little-endian byte-lane enables |
| abort | output | 1 | Unmapped internal address or misaligned access |
| remap_active | output | 1 | Remap has taken effect |

## Verification
The decoder is driven with addresses at the first and last byte of every window and at the byte just past each window. This separates an off-by-one in a comparison from a correct boundary. The same low addresses are replayed before and after the remap strobe, so that boot routing and SRAM routing are told apart. The fixed alias at 0x0030_0000 is checked in both states, to show that it does not depend on remap. Byte, halfword and word accesses at several alignments separate correct lane selection from misalignment aborts. Repeated strobes, an idle bus and a reset in the middle of the run show that remap is sticky, that outputs stay quiet when there is no access, and that reset clears the remap state.

// File: rtl/adrdec_pkg.sv
package adrdec_pkg;

  localparam int AW         = 32;
  localparam int DATA_BYTES = 4;
  localparam int LANE_LOG2  = $clog2(DATA_BYTES);
  localparam int NUM_SEL    = 4;

  localparam int SEL_PSRAM  = 0;
  localparam int SEL_XBANK  = 1;
  localparam int SEL_EBI    = 2;
  localparam int SEL_PERIPH = 3;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    RG_HOLE,
    RG_PSRAM,
    RG_XBANK,
    RG_EBI,
    RG_PERIPH
  } region_e;

  // True when addr lies in [base, base+bytes)
  function automatic logic in_window(input logic [AW-1:0] addr,
                                     input logic [AW-1:0] base,
                                     input logic [AW-1:0] bytes);
    logic [AW-1:0] rel;
    rel = addr - base;
    return (addr >= base) && (rel < bytes);
  endfunction

  // Number of bytes moved by an access of the given size code
  function automatic int unsigned size_bytes(input logic [1:0] sz);
    return 32'd1 << sz;
  endfunction

  // Access fits the data path and is naturally aligned
  function automatic logic is_aligned(input logic [1:0] sz,
                                      input logic [LANE_LOG2-1:0] low);
    int unsigned nb;
    nb = size_bytes(sz);
    if (nb > DATA_BYTES) return 1'b0;
    return (int'(low) % nb) == 0;
  endfunction

  // Little-endian lane mask for an aligned access
  function automatic logic [DATA_BYTES-1:0] lane_mask(input logic [1:0] sz,
                                                      input logic [LANE_LOG2-1:0] low);
    logic [DATA_BYTES-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_BYTES; i++) begin
      if (i >= int'(low) && i < int'(low) + int'(size_bytes(sz))) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Which region each select bit stands for
  function automatic region_e sel_region_of(input int idx);
    case (idx)
      SEL_PSRAM:  return RG_PSRAM;
      SEL_XBANK:  return RG_XBANK;
      SEL_EBI:    return RG_EBI;
      default:    return RG_PERIPH;
    endcase
  endfunction

endpackage

// File: rtl/adrdec_remap_reg.sv
module adrdec_remap_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_strobe,
  output logic remap_q
);

  // Sticky: only reset can clear it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          remap_q <= 1'b0;
    else if (set_strobe) remap_q <= 1'b1;
  end

endmodule

// File: rtl/adrdec_region.sv
module adrdec_region
  import adrdec_pkg::*;
#(
  parameter int unsigned   INT_SPAN_LOG2    = 22,
  parameter int unsigned   PERIPH_SPAN_LOG2 = 22,
  parameter logic [AW-1:0] PSRAM_BYTES      = 32'h0000_2000,
  parameter logic [AW-1:0] PSRAM_ALT_BASE   = 32'h0030_0000,
  parameter logic [AW-1:0] XBANK_BASE       = 32'h0010_0000,
  parameter logic [AW-1:0] XBANK_BYTES      = 32'h0002_0000
) (
  input  logic [AW-1:0] addr,
  input  logic          remapped,
  output region_e       region,
  output logic [AW-1:0] offset,
  output logic          boot_hit
);

  localparam logic [AW-1:0] INT_TOP     = {{(AW-1){1'b0}}, 1'b1} << INT_SPAN_LOG2;
  localparam logic [AW-1:0] PERIPH_BASE = {AW{1'b1}} << PERIPH_SPAN_LOG2;
  localparam logic [AW-1:0] LOW_BASE    = '0;

  logic hit_periph, hit_ebi, hit_alias, hit_xbank, hit_low;

  assign hit_periph = (addr >= PERIPH_BASE);
  assign hit_ebi    = !hit_periph && (addr >= INT_TOP);
  assign hit_alias  = in_window(addr, PSRAM_ALT_BASE, PSRAM_BYTES);
  assign hit_xbank  = in_window(addr, XBANK_BASE, XBANK_BYTES);
  assign hit_low    = in_window(addr, LOW_BASE, PSRAM_BYTES);

  // Priority: top peripherals, middle external, then internal windows
  always_comb begin
    region   = RG_HOLE;
    offset   = '0;
    boot_hit = 1'b0;
    if (hit_periph) begin
      region = RG_PERIPH;
      offset = addr - PERIPH_BASE;
    end else if (hit_ebi) begin
      region = RG_EBI;
      offset = addr;
    end else if (hit_alias) begin
      region = RG_PSRAM;
      offset = addr - PSRAM_ALT_BASE;
    end else if (hit_xbank) begin
      region = RG_XBANK;
      offset = addr - XBANK_BASE;
    end else if (hit_low) begin
      offset = addr - LOW_BASE;
      if (remapped) begin
        region = RG_PSRAM;
      end else begin
        region   = RG_EBI;
        boot_hit = 1'b1;
      end
    end
  end

endmodule

// File: rtl/adrdec_lanes.sv
module adrdec_lanes
  import adrdec_pkg::*;
(
  input  logic [1:0]            size,
  input  logic [LANE_LOG2-1:0]  low,
  output logic                  aligned,
  output logic [DATA_BYTES-1:0] lanes
);

  assign aligned = is_aligned(size, low);
  assign lanes   = aligned ? lane_mask(size, low) : '0;

endmodule

// File: rtl/addr_remap_decoder.sv
module addr_remap_decoder
  import adrdec_pkg::*;
#(
  parameter int unsigned   INT_SPAN_LOG2    = 22,
  parameter int unsigned   PERIPH_SPAN_LOG2 = 22,
  parameter logic [31:0]   PSRAM_BYTES      = 32'h0000_2000,
  parameter logic [31:0]   PSRAM_ALT_BASE   = 32'h0030_0000,
  parameter logic [31:0]   XBANK_BASE       = 32'h0010_0000,
  parameter logic [31:0]   XBANK_BYTES      = 32'h0002_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] bus_addr,
  input  logic        bus_valid,
  input  logic [1:0]  bus_size,
  input  logic        remap_wr,
  output logic [3:0]  sel_region,
  output logic        boot_sel,
  output logic [31:0] region_offset,
  output logic [3:0]  lane_en,
  output logic        abort,
  output logic        remap_active
);

  // Named internal events, visible to the checker
  region_e               dec_region;
  logic [AW-1:0]         dec_offset;
  logic                  dec_boot;
  logic                  acc_aligned;
  logic [DATA_BYTES-1:0] acc_lanes;
  logic                  acc_hit;
  logic                  acc_hole;

  adrdec_remap_reg u_remap (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_strobe (remap_wr),
    .remap_q    (remap_active)
  );

  adrdec_region #(
    .INT_SPAN_LOG2    (INT_SPAN_LOG2),
    .PERIPH_SPAN_LOG2 (PERIPH_SPAN_LOG2),
    .PSRAM_BYTES      (PSRAM_BYTES),
    .PSRAM_ALT_BASE   (PSRAM_ALT_BASE),
    .XBANK_BASE       (XBANK_BASE),
    .XBANK_BYTES      (XBANK_BYTES)
  ) u_region (
    .addr     (bus_addr),
    .remapped (remap_active),
    .region   (dec_region),
    .offset   (dec_offset),
    .boot_hit (dec_boot)
  );

  adrdec_lanes u_lanes (
    .size    (bus_size),
    .low     (bus_addr[LANE_LOG2-1:0]),
    .aligned (acc_aligned),
    .lanes   (acc_lanes)
  );

  assign acc_hole = (dec_region == RG_HOLE);
  assign acc_hit  = bus_valid && acc_aligned && !acc_hole;
  assign abort    = bus_valid && (!acc_aligned || acc_hole);

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    assign sel_region[g] = acc_hit && (dec_region == sel_region_of(g));
  end

  assign boot_sel      = acc_hit && dec_boot;
  assign region_offset = acc_hit ? dec_offset : '0;
  assign lane_en       = acc_hit ? acc_lanes : '0;

endmodule

// File: rtl/adrdec_checker.sv
module adrdec_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] bus_addr,
  input logic        bus_valid,
  input logic [1:0]  bus_size,
  input logic        remap_wr,
  input logic [3:0]  sel_region,
  input logic        boot_sel,
  input logic [3:0]  lane_en,
  input logic        abort,
  input logic        remap_active,
  input logic        acc_aligned
);

  // R8 / R11: at most one select, and never together with abort
  a_r8_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_region));

  a_r8_abort_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (sel_region == 4'b0 && lane_en == 4'b0 && !boot_sel));

  a_r11_misalign_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !acc_aligned) |-> abort);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (sel_region == 4'b0 && !abort && !boot_sel && lane_en == 4'b0));

  a_r9_remap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    remap_wr |=> remap_active);

  a_r9_remap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    remap_active |=> remap_active);

  a_r4_boot_pre_remap: assert property (@(posedge clk) disable iff (!rst_n)
    boot_sel |-> (sel_region == 4'b0100 && !remap_active));

  a_r5_low_psram_after: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && remap_active && acc_aligned && bus_addr < 32'h2000) |-> sel_region == 4'b0001);

  a_r10_word_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_region != 4'b0 && bus_size == 2'd2) |-> lane_en == 4'hF);

endmodule

bind addr_remap_decoder adrdec_checker i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_valid    (bus_valid),
  .bus_size     (bus_size),
  .remap_wr     (remap_wr),
  .sel_region   (sel_region),
  .boot_sel     (boot_sel),
  .lane_en      (lane_en),
  .abort        (abort),
  .remap_active (remap_active),
  .acc_aligned  (acc_aligned)
);

// File: tb/test_addr_remap_decoder.sv
`timescale 1ns/1ps
module test_addr_remap_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_valid = 1'b0;
  logic [1:0]  bus_size = '0;
  logic        remap_wr = 1'b0;
  logic [3:0]  sel_region;
  logic        boot_sel;
  logic [31:0] region_offset;
  logic [3:0]  lane_en;
  logic        abort;
  logic        remap_active;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  addr_remap_decoder i_addr_remap_decoder (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_valid(bus_valid),
    .bus_size(bus_size), .remap_wr(remap_wr), .sel_region(sel_region),
    .boot_sel(boot_sel), .region_offset(region_offset), .lane_en(lane_en),
    .abort(abort), .remap_active(remap_active)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [1:0]  sz;
    logic [3:0]  sel;
    logic        boot;
    logic [31:0] off;
    logic [3:0]  lanes;
    logic        ab;
  } vec_t;

  localparam int NV = 18;
  // Pre-remap vectors: address, size, select, boot, offset, lanes, abort
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 2'd2, 4'b0100, 1'b1, 32'h0000_0000, 4'hF, 1'b0}, // R4
    '{32'h0000_1FFE, 2'd1, 4'b0100, 1'b1, 32'h0000_1FFE, 4'hC, 1'b0}, // R4 R10
    '{32'h0000_2000, 2'd2, 4'b0000, 1'b0, 32'h0000_0000, 4'h0, 1'b1}, // R8
    '{32'h0030_0004, 2'd0, 4'b0001, 1'b0, 32'h0000_0004, 4'h1, 1'b0}, // R6 R10
    '{32'h0030_1FFF, 2'd0, 4'b0001, 1'b0, 32'h0000_1FFF, 4'h8, 1'b0}, // R6 R10
    '{32'h0030_2000, 2'd2, 4'b0000, 1'b0, 32'h0000_0000, 4'h0, 1'b1}, // R8
    '{32'h0010_0000, 2'd2, 4'b0010, 1'b0, 32'h0000_0000, 4'hF, 1'b0}, // R7
    '{32'h0011_FFFC, 2'd2, 4'b0010, 1'b0, 32'h0001_FFFC, 4'hF, 1'b0}, // R7
    '{32'h0012_0000, 2'd2, 4'b0000, 1'b0, 32'h0000_0000, 4'h0, 1'b1}, // R8
    '{32'h0040_0000, 2'd2, 4'b0100, 1'b0, 32'h0040_0000, 4'hF, 1'b0}, // R3
    '{32'hFFBF_FFFC, 2'd2, 4'b0100, 1'b0, 32'hFFBF_FFFC, 4'hF, 1'b0}, // R3
    '{32'hFFC0_0000, 2'd2, 4'b1000, 1'b0, 32'h0000_0000, 4'hF, 1'b0}, // R2
    '{32'hFFFF_FFFE, 2'd1, 4'b1000, 1'b0, 32'h003F_FFFE, 4'hC, 1'b0}, // R2 R10
    '{32'h0000_0001, 2'd1, 4'b0000, 1'b0, 32'h0000_0000, 4'h0, 1'b1}, // R11
    '{32'h0040_0002, 2'd2, 4'b0000, 1'b0, 32'h0000_0000, 4'h0, 1'b1}, // R11
    '{32'h0040_0000, 2'd3, 4'b0000, 1'b0, 32'h0000_0000, 4'h0, 1'b1}, // R11
    '{32'h0030_0001, 2'd0, 4'b0001, 1'b0, 32'h0000_0001, 4'h2, 1'b0}, // R10
    '{32'h0030_0002, 2'd1, 4'b0001, 1'b0, 32'h0000_0002, 4'hC, 1'b0}  // R10
  };

  task automatic expect_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic drive_and_check(input string req, input logic [31:0] a, input logic [1:0] sz,
                                 input logic v, input logic [3:0] sel, input logic boot,
                                 input logic [31:0] off, input logic [3:0] lanes, input logic ab);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_valid = v;
    #1;
    checks++;
    if (sel_region !== sel || boot_sel !== boot || region_offset !== off ||
        lane_en !== lanes || abort !== ab) begin
      fails++;
      $display("FAIL %s addr=%h actual sel=%b boot=%b off=%h lanes=%h abort=%b expected sel=%b boot=%b off=%h lanes=%h abort=%b",
               req, a, sel_region, boot_sel, region_offset, lane_en, abort, sel, boot, off, lanes, ab);
    end
  endtask

  task automatic pulse_remap();
    @(negedge clk); remap_wr = 1'b1;
    @(negedge clk); remap_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    expect_bit("R1 reset remap state", remap_active, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive_and_check("R2-table vector", VECS[i].a, VECS[i].sz, 1'b1, VECS[i].sel,
                      VECS[i].boot, VECS[i].off, VECS[i].lanes, VECS[i].ab);
    end

    // R12: idle bus stays quiet for an address that would hit
    drive_and_check("R12 idle", 32'h0010_0000, 2'd2, 1'b0, 4'b0, 1'b0, 32'h0, 4'h0, 1'b0);
    drive_and_check("R12 idle boot", 32'h0000_0000, 2'd0, 1'b0, 4'b0, 1'b0, 32'h0, 4'h0, 1'b0);

    // R9: the strobe sets the state at the next edge
    @(negedge clk); remap_wr = 1'b1;
    #1 expect_bit("R9 not before edge", remap_active, 1'b0);
    @(negedge clk); remap_wr = 1'b0;
    #1 expect_bit("R9 set after strobe", remap_active, 1'b1);

    // R5: low window now maps the primary SRAM
    drive_and_check("R5 vector base", 32'h0000_0000, 2'd2, 1'b1, 4'b0001, 1'b0, 32'h0, 4'hF, 1'b0);
    drive_and_check("R5 vector top", 32'h0000_001C, 2'd2, 1'b1, 4'b0001, 1'b0, 32'h1C, 4'hF, 1'b0);
    drive_and_check("R5 last byte", 32'h0000_1FFF, 2'd0, 1'b1, 4'b0001, 1'b0, 32'h1FFF, 4'h8, 1'b0);
    drive_and_check("R8 past low window", 32'h0000_2000, 2'd2, 1'b1, 4'b0, 1'b0, 32'h0, 4'h0, 1'b1);
    drive_and_check("R6 alias after remap", 32'h0030_0010, 2'd2, 1'b1, 4'b0001, 1'b0, 32'h10, 4'hF, 1'b0);
    drive_and_check("R3 external after remap", 32'h0040_0000, 2'd2, 1'b1, 4'b0100, 1'b0, 32'h0040_0000, 4'hF, 1'b0);
    drive_and_check("R7 bank after remap", 32'h0010_0008, 2'd1, 1'b1, 4'b0010, 1'b0, 32'h8, 4'h3, 1'b0);

    // R9: further strobes and idle cycles keep it set
    pulse_remap();
    repeat (3) @(negedge clk);
    #1 expect_bit("R9 sticky", remap_active, 1'b1);

    // R1: reset clears it and boot routing returns (R4)
    @(negedge clk); rst_n = 1'b0;
    #1 expect_bit("R1 reset clears remap", remap_active, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    drive_and_check("R4 boot after reset", 32'h0000_0004, 2'd2, 1'b1, 4'b0100, 1'b1, 32'h4, 4'hF, 1'b0);
    drive_and_check("R10 byte lane 2", 32'h0000_0006, 2'd0, 1'b1, 4'b0100, 1'b1, 32'h6, 4'h4, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule